// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block is a small read-only store of instruction words for a 32-bit fetch stage. It has 128 entries, and each entry holds a single 32-bit instruction, so the total capacity is 512 bytes. The fetch stage presents a byte address. The cache answers in the same cycle with a hit flag and the instruction word. To do this it compares the tag stored at the selected entry with the upper address bits, and it checks the entry's valid bit.

On a miss, the fetch unit gets the word from memory by its own means. It then installs the word through a write port that carries an entry index, a tag and the instruction. A lookup may fall on the entry that is being written in the same cycle. In that case the incoming word is returned as a hit at once, so the fetch unit does not have to spend an extra cycle waiting for the store to settle.

Top module: `fetch_icache`

## Requirements
- R1: The lookup address is split as follows: bits 1:0 are ignored, bits 8:2 select one of 128 entries, and bits 31:9 are the 23-bit tag.
- R2: When the write enable is high and the write index equals the lookup index, the hit output is 1 and the instruction output equals the word being written. This holds whatever the lookup tag is.
- R3: In any other case, the hit output is 1 only when the selected entry is valid and its stored tag equals the lookup tag. The instruction output is then the stored word.
- R4: On a miss, the hit output is 0 and the instruction output is all zeros.
- R5: On a clock edge with the write enable high, the tag and the word are stored at the write index and that entry becomes valid. A later lookup with the same index and tag hits and returns that word.
- R6: An active-low reset marks all 128 entries invalid. After reset, every lookup misses until the entry is written.
- R7: The lookup is combinational. Hit and word follow the current address in the same cycle, with no clock edge in between.
- R8: Writing an entry replaces its previous tag and word. A lookup with the old tag then misses, and entries at other indexes keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid bits |
| rd_addr | input | 32 | Fetch byte address for lookup |
| rd_hit | output | 1 | Lookup hit flag |
| rd_inst | output | 32 | Instruction on hit, zero on miss |
| wr_en | input | 1 | Install the word carried by the write port |
| wr_index | input | 7 | Entry to install into |
| wr_tag | input | 23 | Tag to store with the word |
| wr_inst | input | 32 | Instruction word to store |

## Verification
A valid bit that is set but should be clear shows up as a false hit. The false hit appears at the ports in the very cycle that a lookup with a matching stale tag selects the entry. A valid bit that is lost shows up as a miss on a word that was installed earlier. A corrupted tag or word is visible on the first lookup of that entry after the write. For this reason, the bench fills every entry and reads each one back with varied low address bits. It also compares hit and word against its model on every cycle, so any divergence is reported in the same cycle it reaches the ports.

// File: rtl/fic_pkg.sv
package fic_pkg;

    // Where the lookup answer came from
    typedef enum logic [1:0] {
        SRC_MISS    = 2'd0,
        SRC_STORED  = 2'd1,
        SRC_FORWARD = 2'd2
    } fic_src_e;

endpackage

// File: rtl/fic_valid_bits.sv
module fic_valid_bits #(
    parameter int unsigned ENTRIES = 128,
    localparam int unsigned INDEX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [INDEX_W-1:0] rd_index,
    output logic               rd_valid
);

    typedef struct packed {
        logic [ENTRIES-1:0] valid;
    } vstate_t;

    vstate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.valid[wr_index] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid = s_q.valid[rd_index];

    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> s_q.valid[$past(wr_index)]); // R5

    AST_IDLE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.valid)); // R8

    AST_VALID_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($countones(s_q.valid) >= $countones($past(s_q.valid)))); // R5

endmodule

// File: rtl/fic_entry_ram.sv
module fic_entry_ram #(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned WIDTH   = 55,
    localparam int unsigned INDEX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic [INDEX_W-1:0] rd_index,
    output logic [WIDTH-1:0]   rd_data
);

    // Tag and word storage; contents are qualified by the valid bits,
    // so no reset is applied here.
    logic [WIDTH-1:0] mem_d [ENTRIES];
    logic [WIDTH-1:0] mem_q [ENTRIES];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_index] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_index];

endmodule

// File: rtl/fic_hit_select.sv
module fic_hit_select #(
    parameter int unsigned INDEX_W = 7,
    parameter int unsigned TAG_W   = 23,
    parameter int unsigned WORD_W  = 32
) (
    input  logic               rd_valid,
    input  logic [INDEX_W-1:0] rd_index,
    input  logic [TAG_W-1:0]   rd_tag,
    input  logic [TAG_W-1:0]   st_tag,
    input  logic [WORD_W-1:0]  st_word,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [WORD_W-1:0]  wr_word,
    output logic               hit,
    output logic [WORD_W-1:0]  word,
    output fic_pkg::fic_src_e  src
);

    logic fwd_match;
    logic tag_match;

    always_comb begin
        fwd_match = wr_en && (wr_index == rd_index);
        tag_match = rd_valid && (st_tag == rd_tag);
        if (fwd_match) begin
            src = fic_pkg::SRC_FORWARD;
        end else if (tag_match) begin
            src = fic_pkg::SRC_STORED;
        end else begin
            src = fic_pkg::SRC_MISS;
        end
        unique case (src)
            fic_pkg::SRC_FORWARD: begin
                hit  = 1'b1;
                word = wr_word;
            end
            fic_pkg::SRC_STORED: begin
                hit  = 1'b1;
                word = st_word;
            end
            default: begin
                hit  = 1'b0;
                word = '0;
            end
        endcase
    end

endmodule

// File: rtl/fetch_icache.sv
module fetch_icache #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned ENTRIES  = 128,
    parameter int unsigned OFFSET_W = 2,
    localparam int unsigned INDEX_W = $clog2(ENTRIES),
    localparam int unsigned TAG_W   = ADDR_W - INDEX_W - OFFSET_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_hit,
    output logic [WORD_W-1:0]  rd_inst,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [WORD_W-1:0]  wr_inst
);

    localparam int unsigned ENT_W = TAG_W + WORD_W;

    logic [INDEX_W-1:0] rd_index;
    logic [TAG_W-1:0]   rd_tag;
    logic               unused_offset;
    logic               rd_valid;
    logic [ENT_W-1:0]   rd_entry;
    fic_pkg::fic_src_e  rd_src;

    // Address split: offset ignored, index in the middle, tag on top
    assign rd_index      = rd_addr[OFFSET_W +: INDEX_W];
    assign rd_tag        = rd_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = ^rd_addr[OFFSET_W-1:0];

    fic_valid_bits #(
        .ENTRIES (ENTRIES)
    ) u_valid (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_index (wr_index),
        .rd_index (rd_index),
        .rd_valid (rd_valid)
    );

    fic_entry_ram #(
        .ENTRIES (ENTRIES),
        .WIDTH   (ENT_W)
    ) u_ram (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_index (wr_index),
        .wr_data  ({wr_tag, wr_inst}),
        .rd_index (rd_index),
        .rd_data  (rd_entry)
    );

    fic_hit_select #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W),
        .WORD_W  (WORD_W)
    ) u_sel (
        .rd_valid (rd_valid),
        .rd_index (rd_index),
        .rd_tag   (rd_tag),
        .st_tag   (rd_entry[ENT_W-1 -: TAG_W]),
        .st_word  (rd_entry[WORD_W-1:0]),
        .wr_en    (wr_en),
        .wr_index (wr_index),
        .wr_word  (wr_inst),
        .hit      (rd_hit),
        .word     (rd_inst),
        .src      (rd_src)
    );

    AST_FORWARD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_index == rd_index)) |->
            (rd_hit && (rd_inst == wr_inst) && (rd_src == fic_pkg::SRC_FORWARD))); // R2

    AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rd_inst == '0)); // R4

    AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !(wr_en && (wr_index == rd_index))) |-> rd_valid); // R3

    AST_WRITE_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((rd_index == $past(wr_index)) && (rd_tag == $past(wr_tag))
                    && !(wr_en && (wr_index == rd_index)))
                   -> (rd_hit && (rd_inst == $past(wr_inst))))); // R5

endmodule

// File: tb/sim_fetch_icache.sv
module sim_fetch_icache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rd_addr = '0;
    logic        rd_hit;
    logic [31:0] rd_inst;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_index = '0;
    logic [22:0] wr_tag = '0;
    logic [31:0] wr_inst = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Behavioural reference model
    bit          m_valid [128];
    logic [22:0] m_tag   [128];
    logic [31:0] m_word  [128];
    logic [31:0] lfsr = 32'h1ace_b00c;

    always #4 clk = ~clk;

    fetch_icache u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (rd_addr),
        .rd_hit   (rd_hit),
        .rd_inst  (rd_inst),
        .wr_en    (wr_en),
        .wr_index (wr_index),
        .wr_tag   (wr_tag),
        .wr_inst  (wr_inst)
    );

    function automatic logic [31:0] nxt();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // One cycle: drive, compare before the edge, then update model at the edge
    task automatic step(input bit rst, input bit we, input int widx,
                        input logic [22:0] wtag, input logic [31:0] winst,
                        input logic [31:0] raddr, input string req);
        int          ri;
        logic        eh;
        logic [31:0] ew;
        @(negedge clk);
        rst_n    = ~rst;
        wr_en    = we;
        wr_index = widx[6:0];
        wr_tag   = wtag;
        wr_inst  = winst;
        rd_addr  = raddr;
        #2;
        ri = int'(raddr[8:2]);
        if (rst) begin
            for (int k = 0; k < 128; k++) m_valid[k] = 1'b0;
        end
        if (!rst && we && widx == ri) begin
            eh = 1'b1; ew = winst;
        end else if (m_valid[ri] && m_tag[ri] == raddr[31:9]) begin
            eh = 1'b1; ew = m_word[ri];
        end else begin
            eh = 1'b0; ew = '0;
        end
        n_checks++;
        if (rd_hit !== eh || rd_inst !== ew) begin
            n_fail++;
            $display("FAIL %s addr=%h hit=%b inst=%h expected hit=%b inst=%h",
                     req, raddr, rd_hit, rd_inst, eh, ew);
        end
        @(posedge clk);
        if (!rst && we) begin
            m_valid[widx] = 1'b1;
            m_tag[widx]   = wtag;
            m_word[widx]  = winst;
        end
    endtask

    function automatic logic [31:0] mk(input logic [22:0] t, input int idx, input int off);
        return {t, idx[6:0], off[1:0]};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] a;
        // Reset state, R6: everything misses while and after reset
        for (int i = 0; i < 4; i++) step(1, 0, 0, '0, '0, nxt(), "R6 in reset");
        for (int i = 0; i < 20; i++) step(0, 0, 0, '0, '0, nxt(), "R6 after reset");

        // Fill all entries; lookup on the written index forwards, R2 and R7
        for (int i = 0; i < 128; i++) begin
            logic [22:0] t = 23'(nxt());
            step(0, 1, i, t, nxt(), mk(23'(nxt()), i, i), "R2 forward on fill");
        end

        // Read every entry back with each low-bit pattern, R1 R3 R5 R7
        for (int off = 0; off < 4; off++)
            for (int i = 0; i < 128; i++)
                step(0, 0, 0, '0, '0, mk(m_tag[i], i, off), "R1 R3 R5 stored hit");

        // Tag mismatch misses with zero word, R4
        for (int i = 0; i < 128; i++)
            step(0, 0, 0, '0, '0, mk(m_tag[i] ^ 23'h1 << (i % 23), i, 0), "R4 miss zero");

        // Overwrite entry 5 then old tag misses, neighbours kept, R8
        a = mk(m_tag[5], 5, 0);
        step(0, 1, 5, m_tag[5] ^ 23'h40_0000, 32'hdead_beef, mk(m_tag[6], 6, 1), "R8 write other index");
        step(0, 0, 0, '0, '0, a, "R8 old tag misses");
        step(0, 0, 0, '0, '0, mk(m_tag[5], 5, 3), "R8 new tag hits");
        step(0, 0, 0, '0, '0, mk(m_tag[4], 4, 2), "R8 neighbour kept");

        // Forward ignores lookup tag, R2
        step(0, 1, 9, 23'h12345, 32'hcafe_f00d, mk(23'h7ffff, 9, 0), "R2 forward any tag");
        step(0, 0, 0, '0, '0, mk(23'h7ffff, 9, 0), "R2 tag checked after write");

        // Mixed random traffic
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r  = nxt();
            int          wi = int'(r[6:0]);
            logic [31:0] ra = (r[8]) ? mk(m_tag[int'(r[15:9])], int'(r[15:9]), int'(r[17:16]))
                                     : nxt();
            step(0, r[7], wi, 23'(nxt()), nxt(), ra, "R3 R5 random traffic");
        end

        // Reset in mid-run clears valid bits, R6
        step(1, 0, 0, '0, '0, mk(m_tag[3], 3, 0), "R6 reset asserted");
        for (int i = 0; i < 128; i++)
            step(0, 0, 0, '0, '0, mk(m_tag[i], i, 0), "R6 miss after second reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule